// File: doc/BRIEF.md
# Ring-Buffer Peripheral-to-Memory DMA Channel

This block is one DMA channel that takes 16-bit words from a peripheral and writes them into a memory buffer as an endless ring. Software picks a base address and an even buffer length, then raises the enable. From that point each accepted peripheral request writes one word at the next buffer address. After the last slot the address returns to the base and the count of remaining words reloads, with no reprogramming.

A down-counter holds the number of words left in the current pass, and software can read it. The channel signals two boundaries on each pass. The half event fires when the first half of the buffer has been filled, so software can process that half while the second half fills. The complete event fires when the pass ends and the address wraps, so software can process the second half. Each event sets a sticky flag. Software clears a flag by writing one to the matching bit of a clear strobe. An interrupt line is raised while any flag whose enable bit is set is itself set. The channel has no overrun detection: it keeps overwriting whether or not software has serviced the last event.

Top module: `ring_dma_chan`

## Requirements
- R1: A rising edge of `chan_en` latches `ring_base` and `ring_len`, and on the next clock `remain_cnt` equals the latched length. The first transfer after that writes to the latched base address.
- R2: Each cycle in which the channel is running, `chan_en` is high and `per_req` is high, exactly one word is accepted. `per_ack` and `mem_we` are high, `mem_wdata` equals `per_data`, and `mem_addr` equals the base plus the number of words already written in the current pass.
- R3: Every accepted word that is not the last of a pass lowers `remain_cnt` by one.
- R4: The transfer that is accepted while `remain_cnt` is 1 reloads `remain_cnt` to the latched length, and the next transfer writes to the base address again. This repeats indefinitely and holds down to the minimum length of 2.
- R5: `flag_sts` bit 0 (half) sets on the clock of the transfer accepted while `remain_cnt` equals half the length plus one.
- R6: `flag_sts` bit 1 (complete) sets on the clock of the transfer accepted while `remain_cnt` is 1.
- R7: A one on `flag_clr` bit 0 clears the half flag, and a one on bit 1 clears the complete flag. If an event and a clear for the same flag fall in the same cycle, the flag ends up set.
- R8: A set flag stays set until it is cleared. The same event happening again changes nothing, and transfers continue while flags are still pending.
- R9: `irq` is high exactly when (`flag_sts[0]` and `flag_ie[0]`) or (`flag_sts[1]` and `flag_ie[1]`).
- R10: While `chan_en` is low, no request is accepted and `remain_cnt` holds its value.
- R11: After reset, `remain_cnt` is 0, both flags and `irq` are 0, and no request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; a rising edge starts a new ring |
| ring_base | input | AW (16) | Buffer base word address, latched at enable |
| ring_len | input | CW (16) | Buffer length in words (even, at least 2), latched at enable |
| flag_ie | input | 2 | Interrupt enables: bit 0 half, bit 1 complete |
| flag_clr | input | 2 | Write-one-to-clear strobe: bit 0 half, bit 1 complete |
| per_req | input | 1 | Peripheral has a word ready |
| per_data | input | DW (16) | Peripheral data word |
| per_ack | output | 1 | Word accepted this cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW (16) | Memory word address |
| mem_wdata | output | DW (16) | Memory write data |
| remain_cnt | output | CW (16) | Words left in the current pass |
| flag_sts | output | 2 | Sticky flags: bit 0 half, bit 1 complete |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that software only ever presents an even length of at least 2 when it raises the enable. Under that assumption the counter never reaches zero while running, and the half point falls on a whole word. They also assume that `flag_clr` is a one-cycle strobe sampled on the clock. The bench keeps to these assumptions: it enables with lengths 8 and 2, changes `ring_len` and `ring_base` only while the enable is low, and drives every input half a period away from the active edge. It deliberately leaves flags pending across a wrap, so the overwrite-without-error behaviour is exercised.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
  localparam int DATA_W    = 16;
  localparam int NUM_FLAGS = 2;
  localparam int FLAG_HALF = 0;
  localparam int FLAG_FULL = 1;
endpackage

// File: rtl/rdma_rst_sync.sv
module rdma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] base_in,
  input  logic [CW-1:0] len_in,
  output logic          run,
  output logic          start,
  output logic [AW-1:0] base_q,
  output logic [CW-1:0] len_q
);
  logic          run_q;
  logic          run_d;
  logic [AW-1:0] base_d;
  logic [CW-1:0] len_d;

  always_comb begin
    start  = en & ~run_q;
    run_d  = en;
    base_d = start ? base_in : base_q;
    len_d  = start ? len_in  : len_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      base_q <= '0;
      len_q  <= '0;
    end else begin
      run_q <= run_d;
      if (start) begin
        base_q <= base_d;
        len_q  <= len_d;
      end
    end
  end

  assign run = run_q;
endmodule

// File: rtl/rdma_counter.sv
module rdma_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] load_len,
  input  logic [CW-1:0] len_q,
  input  logic          xfer,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] offset,
  output logic          ev_half,
  output logic          ev_full
);
  logic [CW-1:0] cnt_q,  cnt_d;
  logic [CW-1:0] off_q,  off_d;
  logic [CW-1:0] half_mark;
  logic          last_word;
  logic          cnt_en;

  always_comb begin
    half_mark = (len_q >> 1) + CW'(1);
    last_word = (cnt_q == CW'(1));
    ev_full   = xfer & last_word;
    ev_half   = xfer & (cnt_q == half_mark);
    cnt_en    = start | xfer;
    cnt_d     = cnt_q;
    off_d     = off_q;
    if (start) begin
      cnt_d = load_len;
      off_d = '0;
    end else if (xfer) begin
      if (last_word) begin
        cnt_d = len_q;
        off_d = '0;
      end else begin
        cnt_d = cnt_q - CW'(1);
        off_d = off_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      off_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      off_q <= off_d;
    end
  end

  assign cnt    = cnt_q;
  assign offset = off_q;
endmodule

// File: rtl/rdma_flags.sv
module rdma_flags #(
  parameter int NF = ring_dma_pkg::NUM_FLAGS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_ev,
  input  logic [NF-1:0] clr,
  input  logic [NF-1:0] ie,
  output logic [NF-1:0] flags,
  output logic          irq
);
  logic [NF-1:0] flag_q;

  for (genvar g = 0; g < NF; g++) begin : g_flag
    logic flag_d;
    always_comb begin
      flag_d = set_ev[g] | (flag_q[g] & ~clr[g]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[g] <= 1'b0;
      else        flag_q[g] <= flag_d;
    end
  end

  assign flags = flag_q;
  assign irq   = |(flag_q & ie);
endmodule

// File: rtl/ring_dma_chan.sv
module ring_dma_chan #(
  parameter int DW = ring_dma_pkg::DATA_W,
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic [AW-1:0] ring_base,
  input  logic [CW-1:0] ring_len,
  input  logic [1:0]    flag_ie,
  input  logic [1:0]    flag_clr,
  input  logic          per_req,
  input  logic [DW-1:0] per_data,
  output logic          per_ack,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [CW-1:0] remain_cnt,
  output logic [1:0]    flag_sts,
  output logic          irq
);
  import ring_dma_pkg::*;

  logic          rst_int_n;
  logic          chan_run;
  logic          chan_start;
  logic [AW-1:0] base_lat;
  logic [CW-1:0] len_lat;
  logic [CW-1:0] word_off;
  logic          xfer;
  logic [NUM_FLAGS-1:0] events;

  rdma_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  rdma_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en      (chan_en),
    .base_in (ring_base),
    .len_in  (ring_len),
    .run     (chan_run),
    .start   (chan_start),
    .base_q  (base_lat),
    .len_q   (len_lat)
  );

  assign xfer = chan_run & chan_en & per_req;

  rdma_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (chan_start),
    .load_len (ring_len),
    .len_q    (len_lat),
    .xfer     (xfer),
    .cnt      (remain_cnt),
    .offset   (word_off),
    .ev_half  (events[FLAG_HALF]),
    .ev_full  (events[FLAG_FULL])
  );

  rdma_flags #(.NF(NUM_FLAGS)) u_flags (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .set_ev (events),
    .clr    (flag_clr),
    .ie     (flag_ie),
    .flags  (flag_sts),
    .irq    (irq)
  );

  assign per_ack   = xfer;
  assign mem_we    = xfer;
  assign mem_addr  = base_lat + AW'(word_off);
  assign mem_wdata = per_data;
endmodule

// File: rtl/ring_dma_chan_chk.sv
module ring_dma_chan_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chan_en,
  input logic [CW-1:0] ring_len,
  input logic [1:0]    flag_clr,
  input logic          per_ack,
  input logic [AW-1:0] mem_addr,
  input logic [CW-1:0] remain_cnt,
  input logic [1:0]    flag_sts,
  input logic          irq,
  input logic          run,
  input logic [CW-1:0] len_q
);
  // R1
  len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && !run) |-> (ring_len[0] == 1'b0 && ring_len >= CW'(2)));

  // R3
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_ack && remain_cnt != CW'(1)) |=> (remain_cnt == $past(remain_cnt) - CW'(1)));

  // R4
  cnt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_ack && remain_cnt == CW'(1)) |=> (remain_cnt == len_q));

  // R6
  full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_ack && remain_cnt == CW'(1)) |=> flag_sts[1]);

  // R5
  half_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_ack && remain_cnt == ((len_q >> 1) + CW'(1))) |=> flag_sts[0]);

  // R8
  half_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_sts[0] && !flag_clr[0]) |=> flag_sts[0]);

  // R8
  full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_sts[1] && !flag_clr[1]) |=> flag_sts[1]);

  // R10
  no_ack_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> !per_ack);

  // R10
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_ack && !(chan_en && !run)) |=> $stable(remain_cnt));

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_sts == 2'b00) |-> !irq);

  // R2
  run_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |-> (remain_cnt != '0));
endmodule

bind ring_dma_chan ring_dma_chan_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chan_en    (chan_en),
  .ring_len   (ring_len),
  .flag_clr   (flag_clr),
  .per_ack    (per_ack),
  .mem_addr   (mem_addr),
  .remain_cnt (remain_cnt),
  .flag_sts   (flag_sts),
  .irq        (irq),
  .run        (chan_run),
  .len_q      (len_lat)
);

// File: tb/ring_dma_chan_bench.sv
module ring_dma_chan_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam logic [AW-1:0] BASE_A = 16'h0100;

  // fields: req[21] clr[20:19] ack[18] off[17:10] cnt[9:2] half[1] full[0]
  localparam int NV = 21;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 2'b00, 1'b1, 8'd0, 8'd7, 1'b0, 1'b0},
    {1'b0, 2'b00, 1'b0, 8'd1, 8'd7, 1'b0, 1'b0},
    {1'b1, 2'b00, 1'b1, 8'd1, 8'd6, 1'b0, 1'b0},
    {1'b1, 2'b00, 1'b1, 8'd2, 8'd5, 1'b0, 1'b0},
    {1'b1, 2'b00, 1'b1, 8'd3, 8'd4, 1'b1, 1'b0},
    {1'b1, 2'b00, 1'b1, 8'd4, 8'd3, 1'b1, 1'b0},
    {1'b1, 2'b01, 1'b1, 8'd5, 8'd2, 1'b0, 1'b0},
    {1'b1, 2'b00, 1'b1, 8'd6, 8'd1, 1'b0, 1'b0},
    {1'b1, 2'b00, 1'b1, 8'd7, 8'd8, 1'b0, 1'b1},
    {1'b1, 2'b00, 1'b1, 8'd0, 8'd7, 1'b0, 1'b1},
    {1'b1, 2'b10, 1'b1, 8'd1, 8'd6, 1'b0, 1'b0},
    {1'b1, 2'b00, 1'b1, 8'd2, 8'd5, 1'b0, 1'b0},
    {1'b1, 2'b01, 1'b1, 8'd3, 8'd4, 1'b1, 1'b0},
    {1'b1, 2'b00, 1'b1, 8'd4, 8'd3, 1'b1, 1'b0},
    {1'b1, 2'b00, 1'b1, 8'd5, 8'd2, 1'b1, 1'b0},
    {1'b1, 2'b00, 1'b1, 8'd6, 8'd1, 1'b1, 1'b0},
    {1'b1, 2'b00, 1'b1, 8'd7, 8'd8, 1'b1, 1'b1},
    {1'b1, 2'b00, 1'b1, 8'd0, 8'd7, 1'b1, 1'b1},
    {1'b1, 2'b00, 1'b1, 8'd1, 8'd6, 1'b1, 1'b1},
    {1'b1, 2'b00, 1'b1, 8'd2, 8'd5, 1'b1, 1'b1},
    {1'b1, 2'b00, 1'b1, 8'd3, 8'd4, 1'b1, 1'b1}
  };

  logic          clk;
  logic          rst_n;
  logic          chan_en;
  logic [AW-1:0] ring_base;
  logic [CW-1:0] ring_len;
  logic [1:0]    flag_ie;
  logic [1:0]    flag_clr;
  logic          per_req;
  logic [DW-1:0] per_data;
  logic          per_ack;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [CW-1:0] remain_cnt;
  logic [1:0]    flag_sts;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  ring_dma_chan #(.DW(DW), .AW(AW), .CW(CW)) u_ring_dma_chan (
    .clk, .rst_n, .chan_en, .ring_base, .ring_len, .flag_ie, .flag_clr,
    .per_req, .per_data, .per_ack, .mem_we, .mem_addr, .mem_wdata,
    .remain_cnt, .flag_sts, .irq
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; chan_en = 1'b0; ring_base = BASE_A; ring_len = 16'd8;
    flag_ie = 2'b01; flag_clr = 2'b00; per_req = 1'b1; per_data = '0;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11 count", 32'(remain_cnt), 0);
    chk("R11 flags", 32'(flag_sts), 0);
    chk("R11 irq", 32'(irq), 0);
    chk("R11 ack", 32'(per_ack), 0);
    @(negedge clk); rst_n = 1'b1; per_req = 1'b0;
    repeat (3) @(posedge clk);

    // R1 enable latches length
    @(negedge clk); chan_en = 1'b1;
    @(posedge clk); #1;
    chk("R1 count loaded", 32'(remain_cnt), 8);
    chk("R1 flags clear", 32'(flag_sts), 0);

    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      v = VEC[i];
      @(negedge clk);
      per_req  = v[21];
      per_data = 16'(32'hA000 + i);
      flag_clr = v[20:19];
      #1;
      chk("R2 ack", 32'(per_ack), 32'(v[18]));
      if (v[18]) begin
        chk("R2 addr", 32'(mem_addr), 32'(BASE_A + AW'(v[17:10])));
        chk("R2 data", 32'(mem_wdata), 32'(16'(32'hA000 + i)));
        chk("R2 we", 32'(mem_we), 1);
      end
      @(posedge clk); #1;
      chk("R3/R4 count", 32'(remain_cnt), 32'(v[9:2]));
      chk("R5/R7/R8 half", 32'(flag_sts[0]), 32'(v[1]));
      chk("R6/R7/R8 full", 32'(flag_sts[1]), 32'(v[0]));
      chk("R9 irq", 32'(irq), 32'(v[1]));
    end

    // R9 interrupt masking
    @(negedge clk); per_req = 1'b0; flag_ie = 2'b10; flag_clr = 2'b01;
    #1; chk("R9 irq full enabled", 32'(irq), 1);
    @(posedge clk); #1;
    chk("R7 half cleared", 32'(flag_sts), 2);
    chk("R9 irq", 32'(irq), 1);
    @(negedge clk); flag_clr = 2'b10;
    @(posedge clk); #1;
    chk("R7 full cleared", 32'(flag_sts), 0);
    chk("R9 irq low", 32'(irq), 0);

    // R10 disable keeps count, blocks requests
    @(negedge clk); flag_clr = 2'b00; chan_en = 1'b0; per_req = 1'b1;
    #1; chk("R10 no ack", 32'(per_ack), 0);
    @(posedge clk); #1;
    chk("R10 count held", 32'(remain_cnt), 4);
    @(negedge clk); ring_len = 16'd2; ring_base = 16'h0040;
    #1; chk("R10 no ack", 32'(per_ack), 0);
    @(posedge clk); #1;
    chk("R10 count held", 32'(remain_cnt), 4);

    // R1/R4 minimum length ring
    @(negedge clk); per_req = 1'b0; chan_en = 1'b1;
    @(posedge clk); #1;
    chk("R1 relatch", 32'(remain_cnt), 2);
    @(negedge clk); per_req = 1'b1; per_data = 16'h1111;
    #1; chk("R1 first addr", 32'(mem_addr), 32'h40);
    @(posedge clk); #1;
    chk("R3 count", 32'(remain_cnt), 1);
    chk("R5 half len2", 32'(flag_sts), 1);
    @(negedge clk);
    #1; chk("R2 second addr", 32'(mem_addr), 32'h41);
    @(posedge clk); #1;
    chk("R4 reload len2", 32'(remain_cnt), 2);
    chk("R6 full len2", 32'(flag_sts), 3);
    @(negedge clk);
    #1; chk("R4 wrap addr", 32'(mem_addr), 32'h40);
    chk("R4 still running", 32'(per_ack), 1);
    @(posedge clk); #1;
    chk("R4 count", 32'(remain_cnt), 1);

    @(negedge clk); per_req = 1'b0;
    finish_run();
  end
endmodule